// File: doc/BRIEF.md
# Prescaled Four-Channel Down-Counter Timer

This block holds one shared prescaler and a parameterised set of down-counting sub-timers (four by default), all reached through an APB slave port. A free-running `tick_i` strobe drives the prescaler. Each time the prescaler runs out, every enabled sub-timer counts down by one. A sub-timer with its chain bit set ignores the prescaler. It counts down instead when the sub-timer just below it underflows. On underflow a sub-timer either reloads or switches itself off. It can also latch a pending flag and send out a one-cycle interrupt pulse.

The last sub-timer leaves reset already armed as a watchdog. It is enabled, set to restart and set to interrupt, with its counter and reload at all ones. Software must either disable it or keep rewriting it. Each of its underflows also gives a pulse on `wdog_o`. The bus accepts aligned 32-bit words only. Any other access is answered with `pslverr_o` and changes no state.

A two-state bus machine runs each access. `BUS_IDLE` waits for a setup phase. The *setup-seen* transition (`psel_i` high, `penable_i` low) moves it to `BUS_ACCESS`. There `pready_o` is high and the register is read or written. The *access-done* transition then returns it to `BUS_IDLE` on the next clock.

Top module: `tmr_unit`

## Requirements
- R1: In a sub-timer control word, bit 0 (enable), bit 1 (restart), bit 3 (interrupt enable) and bit 5 (chain) are stored from a write, so writing all ones reads back 0x2B when no interrupt is pending.
- R2: Writing a control word with bit 2 set copies that sub-timer's reload value into its counter; bit 2 is never stored.
- R3: Control bit 4 (pending) is set by an underflow while interrupt enable is 1; a write with bit 4 = 0 clears it, a write with bit 4 = 1 leaves it unchanged, and an underflow in the same cycle as a clearing write wins.
- R4: Control bits 2, 6 and 31..7 always read as 0.
- R5: On each tick the prescaler counter decrements; on the tick that takes it from 1 to 0 it is instead reloaded from the prescaler reload register, and every enabled unchained sub-timer steps once, so a reload of N gives one step every N ticks.
- R6: After reset the prescaler value and reload are 0, sub-timers 0..NCH-2 hold 0 in every register, and the last sub-timer reads control 0x0B with counter and reload all ones.
- R7: A transfer with paddr[1:0] not 00, or a write with pstrb not 1111, completes with pslverr high, reads 0 and modifies nothing.
- R8: A step while the counter is 0 is an underflow: with restart set the counter reloads; otherwise the counter stays 0 and enable clears.
- R9: An underflow with interrupt enable set gives exactly one cycle of the sub-timer's irq_o bit, in the cycle after the step; with interrupt enable clear there is no pulse and pending stays 0.
- R10: A sub-timer (other than sub-timer 0) with chain set steps only when the sub-timer below it underflows, not on the prescaler.
- R11: Every underflow of the last sub-timer gives a one-cycle pulse on wdog_o, regardless of its interrupt enable.
- R12: Byte offsets: 0x00 prescaler value, 0x04 prescaler reload; sub-timer i sits at 0x10 + 16*i with counter at +0, reload at +4, control at +8; counter and reload keep the low CW bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaler advance strobe |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | AW | APB byte address |
| pwdata_i | input | 32 | APB write data |
| pstrb_i | input | 4 | APB write byte strobes |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, high in the access phase |
| pslverr_o | output | 1 | APB error for non-word transfers |
| irq_o | output | NCH | One-cycle interrupt pulse per sub-timer |
| wdog_o | output | 1 | One-cycle pulse on last sub-timer underflow |

## Verification
The bench builds the unit with NCH = 4, CW = 8, PW = 8 and AW = 8. The 8-bit counter width makes the armed watchdog's all-ones start value, 255, cheap to run out. So a full watchdog period, with and without its interrupt enabled, fits in a few hundred ticks. The prescaler runs with reloads of 3 and 1 to show both divided and every-tick stepping. A three-level chain stays observable through counter reads alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        BUS_IDLE   = 1'b0,
        BUS_ACCESS = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic ch;
        logic ip;
        logic ie;
        logic rs;
        logic en;
    } tmr_ctl_t;

    localparam int BIT_EN = 0;
    localparam int BIT_RS = 1;
    localparam int BIT_LD = 2;
    localparam int BIT_IE = 3;
    localparam int BIT_IP = 4;
    localparam int BIT_CH = 5;

    // offsets inside one 16-byte slot
    localparam logic [3:0] OFS_CNT = 4'h0;
    localparam logic [3:0] OFS_RLD = 4'h4;
    localparam logic [3:0] OFS_CTL = 4'h8;

    function automatic logic [31:0] ctl_word(tmr_ctl_t c);
        return {26'd0, c.ch, c.ip, c.ie, 1'b0, c.rs, c.en};
    endfunction

endpackage

// File: rtl/tmr_apb_fsm.sv
module tmr_apb_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel_i,
    input  logic       penable_i,
    input  logic       pwrite_i,
    input  logic [1:0] addr_lo_i,
    input  logic [3:0] pstrb_i,
    output logic       pready_o,
    output logic       pslverr_o,
    output logic       wr_en_o,
    output logic       rd_en_o
);

    bus_state_e state_q, state_d;
    logic       bad_w;
    logic       live_w;

    assign bad_w  = (addr_lo_i != 2'b00) || (pwrite_i && (pstrb_i != 4'hF));
    assign live_w = psel_i && penable_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (psel_i && !penable_i) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pready_o  = 1'b0;
        pslverr_o = 1'b0;
        wr_en_o   = 1'b0;
        rd_en_o   = 1'b0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_ACCESS: begin
                pready_o  = 1'b1;
                pslverr_o = live_w && bad_w;
                wr_en_o   = live_w && !bad_w && pwrite_i;
                rd_en_o   = live_w && !bad_w && !pwrite_i;
            end
        endcase
    end

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          wr_cnt_i,
    input  logic          wr_rld_i,
    input  logic [PW-1:0] wdata_i,
    output logic [PW-1:0] cnt_o,
    output logic [PW-1:0] rld_o,
    output logic          fire_o
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] cnt_q, rld_q;

    // the tick that would bring the count to zero reloads instead
    assign fire_o = tick_i && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt_i) begin
            cnt_q <= wdata_i;
        end else if (tick_i) begin
            cnt_q <= fire_o ? rld_q : (cnt_q - ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rld_q <= '0;
        else if (wr_rld_i) rld_q <= wdata_i;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW        = 16,
    parameter bit ARMED     = 1'b0,
    parameter bit CAN_CHAIN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          presc_fire_i,
    input  logic          prev_uf_i,
    input  logic          wr_cnt_i,
    input  logic          wr_rld_i,
    input  logic          wr_ctl_i,
    input  logic [CW-1:0] val_i,
    input  logic [5:0]    ctl_bits_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] rld_o,
    output tmr_ctl_t      ctl_o,
    output logic          uf_o,
    output logic          irq_o
);

    localparam logic [CW-1:0] ONE     = CW'(1);
    localparam logic [CW-1:0] RST_VAL = {CW{ARMED}};
    localparam tmr_ctl_t      RST_CTL = '{ch: 1'b0, ip: 1'b0, ie: ARMED, rs: ARMED, en: ARMED};

    logic [CW-1:0] cnt_q, rld_q;
    tmr_ctl_t      ctl_q;
    logic          irq_q;
    logic          chained_w, step_w, uf_w, load_w;

    assign chained_w = CAN_CHAIN && ctl_q.ch;
    assign step_w    = ctl_q.en && (chained_w ? prev_uf_i : presc_fire_i);
    assign uf_w      = step_w && (cnt_q == '0);
    assign load_w    = wr_ctl_i && ctl_bits_i[BIT_LD];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (wr_cnt_i) begin
            cnt_q <= val_i;
        end else if (load_w) begin
            cnt_q <= rld_q;
        end else if (uf_w) begin
            if (ctl_q.rs) cnt_q <= rld_q;
        end else if (step_w) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        rld_q <= RST_VAL;
        else if (wr_rld_i) rld_q <= val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= RST_CTL;
        end else if (wr_ctl_i) begin
            ctl_q.en <= ctl_bits_i[BIT_EN];
            ctl_q.rs <= ctl_bits_i[BIT_RS];
            ctl_q.ie <= ctl_bits_i[BIT_IE];
            ctl_q.ch <= ctl_bits_i[BIT_CH];
            if (uf_w && ctl_q.ie)        ctl_q.ip <= 1'b1;
            else if (!ctl_bits_i[BIT_IP]) ctl_q.ip <= 1'b0;
        end else begin
            if (uf_w && !ctl_q.rs) ctl_q.en <= 1'b0;
            if (uf_w && ctl_q.ie)  ctl_q.ip <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= uf_w && ctl_q.ie;
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = ctl_q;
    assign uf_o  = uf_w;
    assign irq_o = irq_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int PW  = 16,
    parameter int AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           psel_i,
    input  logic           penable_i,
    input  logic           pwrite_i,
    input  logic [AW-1:0]  paddr_i,
    input  logic [31:0]    pwdata_i,
    input  logic [3:0]     pstrb_i,
    output logic [31:0]    prdata_o,
    output logic           pready_o,
    output logic           pslverr_o,
    output logic [NCH-1:0] irq_o,
    output logic           wdog_o
);

    localparam int SLOT_W = AW - 4;
    localparam logic [SLOT_W-1:0] SCALER_SLOT = '0;

    logic              wr_en, rd_en;
    logic [3:0]        slot_off;
    logic [SLOT_W-1:0] slot;
    logic [PW-1:0]     presc_cnt, presc_rld;
    logic              presc_fire;
    logic [CW-1:0]     cnt_w [NCH];
    logic [CW-1:0]     rld_w [NCH];
    tmr_ctl_t          ctl_w [NCH];
    logic [NCH-1:0]    uf_w, ip_vec, en_vec;
    logic [CW-1:0]     wd_cnt_w;
    logic [31:0]       rdata;
    logic              wdog_q;
    logic              wdata_unused;

    assign slot_off     = paddr_i[3:0];
    assign slot         = paddr_i[AW-1:4];
    assign wdata_unused = ^pwdata_i;

    tmr_apb_fsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .addr_lo_i (paddr_i[1:0]),
        .pstrb_i   (pstrb_i),
        .pready_o  (pready_o),
        .pslverr_o (pslverr_o),
        .wr_en_o   (wr_en),
        .rd_en_o   (rd_en)
    );

    tmr_prescaler #(.PW(PW)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_cnt_i (wr_en && (slot == SCALER_SLOT) && (slot_off == OFS_CNT)),
        .wr_rld_i (wr_en && (slot == SCALER_SLOT) && (slot_off == OFS_RLD)),
        .wdata_i  (pwdata_i[PW-1:0]),
        .cnt_o    (presc_cnt),
        .rld_o    (presc_rld),
        .fire_o   (presc_fire)
    );

    genvar gi;
    for (gi = 0; gi < NCH; gi++) begin : g_ch
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(gi + 1);
        logic hit;
        logic prev_uf;
        assign hit = wr_en && (slot == MY_SLOT);
        if (gi == 0) begin : g_head
            assign prev_uf = 1'b0;
        end else begin : g_link
            assign prev_uf = uf_w[gi-1];
        end
        tmr_channel #(
            .CW        (CW),
            .ARMED     (gi == NCH - 1),
            .CAN_CHAIN (gi != 0)
        ) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .presc_fire_i (presc_fire),
            .prev_uf_i    (prev_uf),
            .wr_cnt_i     (hit && (slot_off == OFS_CNT)),
            .wr_rld_i     (hit && (slot_off == OFS_RLD)),
            .wr_ctl_i     (hit && (slot_off == OFS_CTL)),
            .val_i        (pwdata_i[CW-1:0]),
            .ctl_bits_i   (pwdata_i[5:0]),
            .cnt_o        (cnt_w[gi]),
            .rld_o        (rld_w[gi]),
            .ctl_o        (ctl_w[gi]),
            .uf_o         (uf_w[gi]),
            .irq_o        (irq_o[gi])
        );
        assign ip_vec[gi] = ctl_w[gi].ip;
        assign en_vec[gi] = ctl_w[gi].en;
    end

    assign wd_cnt_w = cnt_w[NCH-1];

    always_comb begin
        rdata = '0;
        if (slot == SCALER_SLOT) begin
            if (slot_off == OFS_CNT)      rdata = 32'(presc_cnt);
            else if (slot_off == OFS_RLD) rdata = 32'(presc_rld);
        end
        for (int i = 0; i < NCH; i++) begin
            if (slot == SLOT_W'(i + 1)) begin
                if (slot_off == OFS_CNT)      rdata = 32'(cnt_w[i]);
                else if (slot_off == OFS_RLD) rdata = 32'(rld_w[i]);
                else if (slot_off == OFS_CTL) rdata = ctl_word(ctl_w[i]);
            end
        end
    end

    assign prdata_o = rd_en ? rdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) wdog_q <= 1'b0;
        else        wdog_q <= uf_w[NCH-1];
    end

    assign wdog_o = wdog_q;

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int AW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwrite_i,
    input logic [AW-1:0]  paddr_i,
    input logic [3:0]     pstrb_i,
    input logic [31:0]    prdata_o,
    input logic           pready_o,
    input logic           pslverr_o,
    input logic [NCH-1:0] irq_o,
    input logic           wdog_o,
    input logic [NCH-1:0] ip_vec,
    input logic [NCH-1:0] en_vec,
    input logic [CW-1:0]  wd_cnt
);

    assert_word_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pready_o && ((paddr_i[1:0] != 2'b00) || (pwrite_i && (pstrb_i != 4'hF)))) |-> pslverr_o);

    assert_ctl_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pready_o && !pwrite_i && !pslverr_o && (paddr_i[3:0] == 4'h8) && (paddr_i[AW-1:4] != '0))
        |-> ((prdata_o[31:6] == '0) && !prdata_o[2]));

    assert_wdog_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_vec[NCH-1] && (wd_cnt == '1)));

    assert_wdog_from_enabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_o |-> $past(en_vec[NCH-1]));

    genvar gi;
    for (gi = 0; gi < NCH; gi++) begin : g_irq
        assert_irq_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[gi] |-> ip_vec[gi]);
    end

endmodule

bind tmr_unit tmr_unit_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pstrb_i   (pstrb_i),
    .prdata_o  (prdata_o),
    .pready_o  (pready_o),
    .pslverr_o (pslverr_o),
    .irq_o     (irq_o),
    .wdog_o    (wdog_o),
    .ip_vec    (ip_vec),
    .en_vec    (en_vec),
    .wd_cnt    (wd_cnt_w)
);

// File: tb/tmr_unit_tb.sv
module tmr_unit_tb;

    localparam int NCH = 4;
    localparam int CW  = 8;
    localparam int PW  = 8;
    localparam int AW  = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tick_i;
    logic           psel_i, penable_i, pwrite_i;
    logic [AW-1:0]  paddr_i;
    logic [31:0]    pwdata_i;
    logic [3:0]     pstrb_i;
    logic [31:0]    prdata_o;
    logic           pready_o, pslverr_o;
    logic [NCH-1:0] irq_o;
    logic           wdog_o;

    always #5 clk = ~clk;

    tmr_unit #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .psel_i    (psel_i),
        .penable_i (penable_i),
        .pwrite_i  (pwrite_i),
        .paddr_i   (paddr_i),
        .pwdata_i  (pwdata_i),
        .pstrb_i   (pstrb_i),
        .prdata_o  (prdata_o),
        .pready_o  (pready_o),
        .pslverr_o (pslverr_o),
        .irq_o     (irq_o),
        .wdog_o    (wdog_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen [NCH] = '{default: 0};
    int wd_seen = 0;

    always @(posedge clk) begin
        for (int i = 0; i < NCH; i++) if (irq_o[i] === 1'b1) irq_seen[i]++;
        if (wdog_o === 1'b1) wd_seen++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          output logic e);
        @(negedge clk);
        psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b1;
        paddr_i = a; pwdata_i = d; pstrb_i = s;
        @(negedge clk);
        penable_i = 1'b1;
        #1 e = pslverr_o;
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        psel_i = 1'b1; penable_i = 1'b0; pwrite_i = 1'b0;
        paddr_i = a; pstrb_i = 4'h0;
        @(negedge clk);
        penable_i = 1'b1;
        #1 begin d = prdata_o; e = pslverr_o; end
        @(negedge clk);
        psel_i = 1'b0; penable_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic e;
        bus_wr(a, d, 4'hF, e);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        bus_rd(a, d, e);
        check(tag, d, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [7:0]  a;
        logic [31:0] d;
        logic [3:0]  s;
        logic [31:0] x;
        logic        xe;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h48, 32'h0,        4'h0, 32'h0000_000B, 1'b0, 4'd6},  // R6 watchdog ctrl
        '{1'b0, 8'h40, 32'h0,        4'h0, 32'h0000_00FF, 1'b0, 4'd6},  // R6 watchdog count
        '{1'b0, 8'h44, 32'h0,        4'h0, 32'h0000_00FF, 1'b0, 4'd6},  // R6 watchdog reload
        '{1'b0, 8'h18, 32'h0,        4'h0, 32'h0,         1'b0, 4'd6},  // R6 timer0 ctrl
        '{1'b0, 8'h00, 32'h0,        4'h0, 32'h0,         1'b0, 4'd6},  // R6 prescaler
        '{1'b1, 8'h18, 32'hFFFF_FFFF,4'hF, 32'h0,         1'b0, 4'd1},  // R1 write all ones
        '{1'b0, 8'h18, 32'h0,        4'h0, 32'h0000_002B, 1'b0, 4'd1},  // R1 R4 mask
        '{1'b1, 8'h14, 32'h0000_125A,4'hF, 32'h0,         1'b0, 4'd12}, // R12 timer0 reload
        '{1'b0, 8'h14, 32'h0,        4'h0, 32'h0000_005A, 1'b0, 4'd12}, // R12 truncation
        '{1'b1, 8'h18, 32'h0000_0004,4'hF, 32'h0,         1'b0, 4'd2},  // R2 load strobe
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h0000_005A, 1'b0, 4'd2},  // R2 counter loaded
        '{1'b0, 8'h18, 32'h0,        4'h0, 32'h0,         1'b0, 4'd2},  // R2 bit not stored
        '{1'b1, 8'h11, 32'h0,        4'hF, 32'h0,         1'b1, 4'd7},  // R7 misaligned write
        '{1'b0, 8'h12, 32'h0,        4'h0, 32'h0,         1'b1, 4'd7},  // R7 misaligned read
        '{1'b1, 8'h10, 32'h0000_0033,4'h3, 32'h0,         1'b1, 4'd7},  // R7 partial strobe
        '{1'b0, 8'h10, 32'h0,        4'h0, 32'h0000_005A, 1'b0, 4'd7},  // R7 counter untouched
        '{1'b1, 8'h24, 32'h0000_0077,4'hF, 32'h0,         1'b0, 4'd12}, // R12 timer1 reload
        '{1'b0, 8'h24, 32'h0,        4'h0, 32'h0000_0077, 1'b0, 4'd12}, // R12 readback
        '{1'b0, 8'h34, 32'h0,        4'h0, 32'h0,         1'b0, 4'd12}, // R12 timer2 untouched
        '{1'b1, 8'h04, 32'h0000_0003,4'hF, 32'h0,         1'b0, 4'd5},  // R5 prescaler reload
        '{1'b0, 8'h04, 32'h0,        4'h0, 32'h0000_0003, 1'b0, 4'd5}   // R5 readback
    };

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 run timeout: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        e;
        int          i0, i1, i3, w0;
        rst_n = 1'b0; tick_i = 1'b0;
        psel_i = 1'b0; penable_i = 1'b0; pwrite_i = 1'b0;
        paddr_i = '0; pwdata_i = '0; pstrb_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 no irq at reset", 32'(irq_o), 32'h0);
        check("R11 no watchdog pulse at reset", 32'(wdog_o), 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) begin
                bus_wr(VECS[k].a, VECS[k].d, VECS[k].s, e);
            end else begin
                bus_rd(VECS[k].a, d, e);
                check($sformatf("R%0d vector %0d data", VECS[k].req, k), d, VECS[k].x);
            end
            check($sformatf("R%0d vector %0d error", VECS[k].req, k), 32'(e), 32'(VECS[k].xe));
        end

        // R5 divided stepping with restart
        wr(8'h48, 32'h0);
        wr(8'h00, 32'h3);
        wr(8'h14, 32'h2);
        wr(8'h18, 32'h0F);
        i0 = irq_seen[0];
        ticks(8);
        rd_chk("R5 timer0 after two prescaler periods", 8'h10, 32'h0);
        rd_chk("R5 prescaler count", 8'h00, 32'h1);
        check("R5 no early interrupt", 32'(irq_seen[0] - i0), 32'h0);
        ticks(1);
        check("R9 one pulse on underflow", 32'(irq_seen[0] - i0), 32'h1);
        rd_chk("R8 restart reloads", 8'h10, 32'h2);
        rd_chk("R3 pending set", 8'h18, 32'h1B);

        // R3 write-zero-to-clear
        wr(8'h18, 32'h1B);
        rd_chk("R3 write one keeps pending", 8'h18, 32'h1B);
        wr(8'h18, 32'h0B);
        rd_chk("R3 write zero clears pending", 8'h18, 32'h0B);

        // R8 underflow without restart
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        wr(8'h18, 32'h09);
        ticks(3);
        rd_chk("R8 enable cleared", 8'h18, 32'h18);
        rd_chk("R8 counter held at zero", 8'h10, 32'h0);
        check("R9 second pulse", 32'(irq_seen[0] - i0), 32'h2);
        ticks(2);
        check("R8 stopped timer silent", 32'(irq_seen[0] - i0), 32'h2);

        // R10 chaining, R9 interrupt disabled
        i1 = irq_seen[1];
        wr(8'h24, 32'h1);
        wr(8'h28, 32'h07);
        wr(8'h34, 32'h5);
        wr(8'h38, 32'h2F);
        ticks(4);
        rd_chk("R10 chained timer stepped twice", 8'h30, 32'h3);
        check("R9 no pulse with ie clear", 32'(irq_seen[1] - i1), 32'h0);
        rd_chk("R9 pending stays clear", 8'h28, 32'h03);

        // R6 reset again, then R11 watchdog run-out
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd_chk("R6 timer2 ctrl cleared", 8'h38, 32'h0);
        rd_chk("R6 watchdog ctrl rearmed", 8'h48, 32'h0B);
        wr(8'h04, 32'h1);
        wr(8'h00, 32'h1);
        w0 = wd_seen;
        i3 = irq_seen[3];
        ticks(255);
        rd_chk("R11 watchdog at zero", 8'h40, 32'h0);
        check("R11 no pulse before underflow", 32'(wd_seen - w0), 32'h0);
        ticks(1);
        check("R11 watchdog pulse", 32'(wd_seen - w0), 32'h1);
        check("R9 watchdog interrupt", 32'(irq_seen[3] - i3), 32'h1);
        rd_chk("R8 watchdog reloaded", 8'h40, 32'h0000_00FF);
        rd_chk("R3 watchdog pending", 8'h48, 32'h1B);
        wr(8'h48, 32'h07);
        ticks(256);
        check("R11 pulse with ie clear", 32'(wd_seen - w0), 32'h2);
        check("R9 no watchdog irq with ie clear", 32'(irq_seen[3] - i3), 32'h1);

        summary();
        $finish;
    end

endmodule